// File: doc/BRIEF.md
# Fuse-Configurable AND-OR Logic Array

This block is a soft model of a small sum-of-products logic device. Ten input pins each feed an AND plane in both their plain and inverted form. That gives every product row twenty literal columns. Every output owns eight product rows:

- Seven of the rows are ORed to form the output's data value.
- The last row acts as the output's drive enable.

Each column of each row holds one fuse. A fuse that is still intact keeps its literal in the product. A fuse that has been blown drops the literal from the product.

The fuse map lives in one long register and is written serially. While `cfg_load` is high, every cycle with `cfg_valid` high takes in one bit from `cfg_data`. There is no back-pressure on this port: `cfg_ready` simply mirrors `cfg_load`, so every valid bit offered during a load is accepted in the cycle it is offered. A bit offered while `cfg_load` is low is not taken.

Once a load has finished, the path from `pin_in` to `pin_out`/`pin_oe` is purely combinational. The drive enable is brought out as a separate bit for each output. No internal net is left floating.

Top module: `pla_fuse_array`

## Requirements
- R1: After reset, and before any load has completed, `pin_oe` and `pin_out` are all zero whatever `pin_in` does.
- R2: A bit is shifted in on each rising clock edge where `cfg_load` and `cfg_valid` are both high. The first bit of a load ends up in fuse index 1279 and the last in index 0. Fuse index = ((output*8)+row)*20 + column.
- R3: `cfg_ready` equals `cfg_load`. A cycle with `cfg_valid` low does not alter the map, whatever `cfg_data` carries.
- R4: While `cfg_load` is high, `pin_oe` and `pin_out` are all zero. The new map takes effect from the cycle after `cfg_load` falls.
- R5: Column 2*i carries input i in its plain form and column 2*i+1 carries it inverted. A stored 1 is an intact fuse, which keeps the literal in the product. A stored 0 is a blown fuse, which drops it.
- R6: A row with every fuse intact evaluates to 0 and adds nothing to its output's OR.
- R7: A row with every fuse blown evaluates to 1. When it is one of rows 0..6, it forces its output's data to 1.
- R8: The data value of an output is the OR of its rows 0 to 6.
- R9: Row 7 of each output drives that output's `pin_oe`. An output whose enable row is 0 shows 0 on `pin_out`.
- R10: Once a map is in place, `pin_out` and `pin_oe` follow a change of `pin_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | High for the duration of a map load |
| cfg_valid | input | 1 | A fuse bit is offered on `cfg_data` |
| cfg_ready | output | 1 | Bit acceptance, equal to `cfg_load` |
| cfg_data | input | 1 | Serial fuse bit (1 = intact) |
| pin_in | input | 10 | Dedicated logic inputs |
| pin_out | output | 8 | Output data, 0 while the output is disabled |
| pin_oe | output | 8 | Per-output drive enable |

## Verification
The bench builds the block with its default parameters: ten inputs, eight outputs and seven summed rows. That is the full 1280-bit map. With these values, each of the following shows up at the pins:

- the split between plain and inverted columns;
- the position of the enable row;
- the ordering of the serial stream.

One map holds the two-term XOR, a constant-one output, an all-intact output and an input-driven enable side by side. A second, pseudo-random map is loaded with invalid cycles carrying wrong data between the valid bits. This shows that only accepted bits land, and that they land at the stated indices.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned DEF_INPUTS    = 10;
  localparam int unsigned DEF_OUTPUTS   = 8;
  localparam int unsigned DEF_SUM_TERMS = 7;

  // Column position of the literal for input i, plain or inverted.
  function automatic int unsigned lit_col(input int unsigned i, input bit inverted);
    return 2 * i + (inverted ? 1 : 0);
  endfunction
endpackage

// File: rtl/pla_fuse_shift.sv
module pla_fuse_shift #(
  parameter int unsigned FUSES = 1280
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_valid,
  input  logic             cfg_data,
  output logic [FUSES-1:0] fuse_map,
  output logic             array_active
);
  logic seen_load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_map <= '0;
    end else if (cfg_load && cfg_valid) begin
      fuse_map <= {fuse_map[FUSES-2:0], cfg_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_load_q <= 1'b0;
    else if (cfg_load) seen_load_q <= 1'b1;
  end

  assign array_active = seen_load_q & ~cfg_load;

  // R2
  shift_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_valid) |=> (fuse_map[0] == $past(cfg_data)))
    else $error("shift did not take the offered bit");

  // R3
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_load && cfg_valid) |=> $stable(fuse_map))
    else $error("map changed without an accepted bit");

  // R4
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !array_active)
    else $error("array active during load");
endmodule

// File: rtl/pla_product_term.sv
module pla_product_term #(
  parameter int unsigned COLS = 20
) (
  input  logic [COLS-1:0] fuses,
  input  logic [COLS-1:0] literals,
  output logic            term
);
  // An intact fuse (1) requires its literal; a blown fuse (0) masks it.
  assign term = &(literals | ~fuses);

  always_comb begin
    // R6
    if (&fuses) begin
      all_intact_chk: assert (term == 1'b0) else $error("all-intact row not zero");
    end
    // R7
    if (fuses == '0) begin
      all_blown_chk: assert (term == 1'b1) else $error("all-blown row not one");
    end
  end
endmodule

// File: rtl/pla_output_cell.sv
module pla_output_cell #(
  parameter int unsigned TERMS = 8
) (
  input  logic [TERMS-1:0] terms,
  input  logic             active,
  output logic             dout,
  output logic             oe
);
  localparam int unsigned SUMS = TERMS - 1;

  logic sum;
  assign sum  = |terms[SUMS-1:0];
  assign oe   = active & terms[TERMS-1];
  assign dout = oe & sum;

  always_comb begin
    // R4
    if (active == 1'b0) begin
      idle_cell_chk: assert (oe == 1'b0 && dout == 1'b0) else $error("idle cell drives");
    end
    // R9
    if (oe == 1'b0) begin
      off_zero_chk: assert (dout == 1'b0) else $error("disabled output not zero");
    end
  end
endmodule

// File: rtl/pla_fuse_array.sv
module pla_fuse_array #(
  parameter int unsigned N_IN      = pla_pkg::DEF_INPUTS,
  parameter int unsigned N_OUT     = pla_pkg::DEF_OUTPUTS,
  parameter int unsigned SUM_TERMS = pla_pkg::DEF_SUM_TERMS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  localparam int unsigned TERMS = SUM_TERMS + 1;
  localparam int unsigned COLS  = 2 * N_IN;
  localparam int unsigned ROWS  = N_OUT * TERMS;
  localparam int unsigned FUSES = ROWS * COLS;

  logic [FUSES-1:0] fuse_map;
  logic             array_active;
  logic [COLS-1:0]  literals;
  logic [ROWS-1:0]  row_terms;

  assign cfg_ready = cfg_load;

  pla_fuse_shift #(.FUSES(FUSES)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_valid    (cfg_valid),
    .cfg_data     (cfg_data),
    .fuse_map     (fuse_map),
    .array_active (array_active)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign literals[pla_pkg::lit_col(i, 1'b0)] = pin_in[i];
    assign literals[pla_pkg::lit_col(i, 1'b1)] = ~pin_in[i];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pla_product_term #(.COLS(COLS)) u_term (
      .fuses    (fuse_map[r*COLS +: COLS]),
      .literals (literals),
      .term     (row_terms[r])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pla_output_cell #(.TERMS(TERMS)) u_cell (
      .terms  (row_terms[o*TERMS +: TERMS]),
      .active (array_active),
      .dout   (pin_out[o]),
      .oe     (pin_oe[o])
    );
  end

  // R4
  load_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (pin_oe == '0 && pin_out == '0))
    else $error("outputs live during load");

  // R3
  ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready == cfg_load)
    else $error("ready does not follow load");

  // R9
  out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0)
    else $error("data on a disabled output");
endmodule

// File: tb/tb_pla_fuse_array.sv
module tb_pla_fuse_array;
  localparam int unsigned N_IN  = 10;
  localparam int unsigned N_OUT = 8;
  localparam int unsigned TERMS = 8;
  localparam int unsigned COLS  = 20;
  localparam int unsigned FUSES = N_OUT * TERMS * COLS;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_valid = 1'b0, cfg_data = 1'b0;
  logic cfg_ready;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_OUT-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [FUSES-1:0] tb_map;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_fuse_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_data(cfg_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model straight from R5..R9.
  task automatic ref_eval(input logic [N_IN-1:0] x, output logic [N_OUT-1:0] d,
                          output logic [N_OUT-1:0] e);
    for (int o = 0; o < N_OUT; o++) begin
      logic sum = 1'b0;
      logic en  = 1'b0;
      for (int t = 0; t < TERMS; t++) begin
        logic prod = 1'b1;
        for (int c = 0; c < COLS; c++) begin
          logic lit = (c % 2 == 0) ? x[c/2] : ~x[c/2];
          if (tb_map[((o*TERMS)+t)*COLS + c] && !lit) prod = 1'b0;
        end
        if (t == TERMS-1) en = prod;
        else sum |= prod;
      end
      e[o] = en;
      d[o] = en & sum;
    end
  endtask

  task automatic set_row(input int o, input int t, input logic [COLS-1:0] f);
    tb_map[((o*TERMS)+t)*COLS +: COLS] = f;
  endtask

  // Streams tb_map MSB first; gaps inserts invalid cycles with wrong data.
  task automatic load_map(input bit gaps, input string req);
    @(negedge clk);
    cfg_load = 1'b1;
    for (int k = FUSES-1; k >= 0; k--) begin
      if (gaps && (k % 3 == 0)) begin
        cfg_valid = 1'b0;
        cfg_data  = ~tb_map[k];
        @(negedge clk);
      end
      cfg_valid = 1'b1;
      cfg_data  = tb_map[k];
      if (k == FUSES/2) begin
        #1;
        check({req, " R4 oe during load"}, {8'h0, pin_oe}, 16'h0);
        check({req, " R3 ready during load"}, {15'h0, cfg_ready}, 16'h1);
      end
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    cfg_load  = 1'b0;
    @(negedge clk);
  endtask

  task automatic apply_and_check(input logic [N_IN-1:0] x, input string req);
    logic [N_OUT-1:0] d, e;
    pin_in = x;
    #1;
    ref_eval(x, d, e);
    check({req, " out"}, {8'h0, pin_out}, {8'h0, d});
    check({req, " oe"},  {8'h0, pin_oe},  {8'h0, e});
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) begin
      pin_in = N_IN'(k * 173);
      #1;
      check("R1 reset out", {8'h0, pin_out}, 16'h0);
      check("R1 reset oe",  {8'h0, pin_oe},  16'h0);
      check("R3 ready idle", {15'h0, cfg_ready}, 16'h0);
    end
  endtask

  task automatic t_directed;
    tb_map = '1;
    // output 0: XOR of in0,in1 via rows 0,1 (R5), others intact (R6), enable blown
    set_row(0, 0, 20'h0 | (20'h1 << 0) | (20'h1 << 3));
    set_row(0, 1, 20'h0 | (20'h1 << 1) | (20'h1 << 2));
    set_row(0, 7, 20'h0);
    // output 1: row 0 all blown -> constant 1 (R7)
    set_row(1, 0, 20'h0);
    set_row(1, 7, 20'h0);
    // output 2: all sum rows intact, enabled -> 0 (R6)
    set_row(2, 7, 20'h0);
    // output 3: data = in5, enable = in9 (R9)
    set_row(3, 0, 20'h1 << 10);
    set_row(3, 7, 20'h1 << 18);
    // outputs 4..7: all intact including enable -> disabled
    load_map(1'b0, "R2");
    for (int k = 0; k < 4; k++) begin
      logic [N_IN-1:0] x = {k[1] ? 1'b1 : 1'b0, 3'b000, k[0], 3'b000, k[1], k[0]};
      apply_and_check(x, "R8 xor");
      check("R8 xor bit", {15'h0, pin_out[0]}, {15'h0, x[0] ^ x[1]});
      check("R7 const one", {15'h0, pin_out[1]}, 16'h1);
      check("R6 intact zero", {15'h0, pin_out[2]}, 16'h0);
      check("R9 enable row", {15'h0, pin_oe[3]}, {15'h0, x[9]});
      check("R9 disabled tail", {12'h0, pin_oe[7:4]}, 16'h0);
    end
    // R10: change inputs with no clock edge between
    @(posedge clk); #2;
    apply_and_check(10'h201, "R10 a");
    apply_and_check(10'h002, "R10 b");
    apply_and_check(10'h220, "R10 c");
  endtask

  task automatic t_random_gaps;
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < FUSES; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tb_map[k] = lfsr[0] | lfsr[3];
    end
    // keep some rows decisive so the map shows through
    set_row(5, 2, 20'h0 | (20'h1 << 8));
    set_row(5, 7, 20'h0);
    set_row(6, 7, 20'h1 << 1);
    load_map(1'b1, "R3 gaps");
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply_and_check(lfsr[N_IN-1:0], "R2 R3 R5 random");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_directed;
    t_random_gaps;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule